// File: doc/BRIEF.md
# Vehicle Bus Frame CRC-8 Generator and Checker

This block computes the 8-bit check byte of a vehicle serial bus frame and verifies it on reception. A frame opens with a one-cycle `frame_start` strobe, which presets the running remainder to all ones and samples the direction on `mode_rx`. Each byte presented with `byte_valid` is folded into the remainder in a single clock, most significant bit first, through the divisor x^8 + x^4 + x^3 + x^2 + 1. Framing symbols are never fed in, so only payload bytes are counted.

In transmit mode (`mode_rx` low at the start strobe) the bitwise inverse of the remainder is always on `crc_out`, ready to be appended after the last payload byte. In receive mode the received check byte is fed through the same path. An intact frame then leaves the remainder at 0xC4, whatever the payload. On `frame_end` the block sets `crc_ok` and holds it until the next frame opens. The controller is a three-state machine. IDLE is the state after reset. OPEN is entered from IDLE or CLOSED by the start transition, and OPEN re-enters itself on a restart. CLOSED is entered from OPEN by the end transition. The machine leaves CLOSED only through a start.

Top module: `crc8_j1850`

## Requirements
- R1: After reset `crc_ok` is 0 and `crc_out` is 0x00, which is the inverse of the 0xFF preset. No frame is open.
- R2: `frame_start` presets the remainder to 0xFF, so `crc_out` is 0x00 in the next cycle, and clears `crc_ok`. It takes priority over `byte_valid` and `frame_end` in the same cycle.
- R3: Each byte accepted in an open frame is processed MSB first with divisor 0x1D in one clock. `crc_out` equals the inverse of the new remainder in the cycle after the strobe.
- R4: In transmit mode the nine ASCII bytes "123456789" give `crc_out` = 0x4B.
- R5: In receive mode, a frame whose last byte is the correct check byte leaves `crc_out` = 0x3B (remainder 0xC4) and sets `crc_ok` to 1 at `frame_end`.
- R6: In receive mode, any final remainder other than 0xC4 gives `crc_ok` = 0 at `frame_end`.
- R7: A frame with no accepted byte between start and end gives `crc_ok` = 0 in either mode.
- R8: `crc_ok` changes only on a `frame_end` in an open frame, or on `frame_start`. A `frame_end` while no frame is open is ignored.
- R9: `byte_valid` while no frame is open (before the first start, or after an end) leaves `crc_out` unchanged.
- R10: When `byte_valid` and `frame_end` arrive in the same cycle, that byte is included in the checked remainder.
- R11: The direction is sampled at `frame_start`. Changes on `mode_rx` inside a frame have no effect. A non-empty transmit frame ends with `crc_ok` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Opens a frame and presets the remainder |
| mode_rx | input | 1 | 1 = receive/check, 0 = transmit/generate; sampled with frame_start |
| byte_in | input | 8 | Frame byte |
| byte_valid | input | 1 | byte_in is valid this cycle |
| frame_end | input | 1 | Closes the open frame and updates crc_ok |
| crc_out | output | 8 | Inverse of the running remainder (check byte to append) |
| crc_ok | output | 1 | Result of the last closed frame |

## Verification
The bound checker checks the following on every cycle: the preset after a start, the stability of `crc_ok` between frame events, the stability of `crc_out` when bytes arrive outside a frame, the failure flag on empty frames, and the 0x3B output that must accompany a passing receive frame. Only the scenarios in the bench can show the polynomial arithmetic itself. These cover the known nine-byte vector, generated check bytes looped back through receive mode, corrupted payloads and check bytes, same-cycle strobe collisions, and mode changes inside a frame.

// File: rtl/crc8_j1850_pkg.sv
package crc8_j1850_pkg;

    localparam int          CRC_W   = 8;
    localparam int          DATA_W  = 8;
    localparam logic [7:0]  POLY    = 8'h1D;
    localparam logic [7:0]  PRESET  = 8'hFF;
    localparam logic [7:0]  RESIDUE = 8'hC4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_CLOSED = 2'd2
    } frame_state_e;

endpackage

// File: rtl/crc8_byte_step.sv
// Combinational fold of one data word into the remainder, MSB first.
module crc8_byte_step #(
    parameter int               CW   = 8,
    parameter int               DW   = 8,
    parameter logic [CW-1:0]    POLY = 8'h1D
) (
    input  logic [CW-1:0] rem_in,
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] rem_out
);

    logic [CW-1:0] chain [DW+1];

    assign chain[0] = rem_in;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic fb;
        assign fb         = chain[i][CW-1] ^ data_in[DW-1-i];
        assign chain[i+1] = {chain[i][CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign rem_out = chain[DW];

endmodule

// File: rtl/crc8_frame_fsm.sv
// Frame control: IDLE -> OPEN (start), OPEN -> CLOSED (end),
// CLOSED -> OPEN (start), OPEN -> OPEN (restart).
module crc8_frame_fsm
    import crc8_j1850_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic byte_valid,
    input  logic frame_end,
    output logic load_preset,
    output logic accept_byte,
    output logic close_frame,
    output logic frame_open
);

    frame_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_start) state_d = ST_OPEN;
            ST_OPEN: begin
                if (frame_start)    state_d = ST_OPEN;
                else if (frame_end) state_d = ST_CLOSED;
            end
            ST_CLOSED: if (frame_start) state_d = ST_OPEN;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_preset = frame_start;
        accept_byte = 1'b0;
        close_frame = 1'b0;
        frame_open  = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                frame_open  = 1'b1;
                accept_byte = byte_valid && !frame_start;
                close_frame = frame_end  && !frame_start;
            end
            ST_IDLE, ST_CLOSED: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/crc8_j1850.sv
module crc8_j1850
    import crc8_j1850_pkg::*;
#(
    parameter int               CW      = CRC_W,
    parameter int               DW      = DATA_W,
    parameter logic [CW-1:0]    DIVISOR = POLY,
    parameter logic [CW-1:0]    INIT    = PRESET,
    parameter logic [CW-1:0]    GOOD    = RESIDUE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          mode_rx,
    input  logic [DW-1:0] byte_in,
    input  logic          byte_valid,
    input  logic          frame_end,
    output logic [CW-1:0] crc_out,
    output logic          crc_ok
);

    logic          load_preset, accept_byte, close_frame, frame_open;
    logic [CW-1:0] rem_q, rem_step, rem_final;
    logic          any_byte_q, mode_q, ok_q;

    crc8_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .byte_valid  (byte_valid),
        .frame_end   (frame_end),
        .load_preset (load_preset),
        .accept_byte (accept_byte),
        .close_frame (close_frame),
        .frame_open  (frame_open)
    );

    crc8_byte_step #(.CW(CW), .DW(DW), .POLY(DIVISOR)) u_step (
        .rem_in  (rem_q),
        .data_in (byte_in),
        .rem_out (rem_step)
    );

    // Remainder seen by the close check, including a same-cycle byte.
    assign rem_final = accept_byte ? rem_step : rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q      <= INIT;
            any_byte_q <= 1'b0;
            mode_q     <= 1'b0;
            ok_q       <= 1'b0;
        end else if (load_preset) begin
            rem_q      <= INIT;
            any_byte_q <= 1'b0;
            mode_q     <= mode_rx;
            ok_q       <= 1'b0;
        end else begin
            if (accept_byte) begin
                rem_q      <= rem_step;
                any_byte_q <= 1'b1;
            end
            if (close_frame)
                ok_q <= (any_byte_q || accept_byte) &&
                        (!mode_q || (rem_final == GOOD));
        end
    end

    assign crc_out = ~rem_q;
    assign crc_ok  = ok_q;

endmodule

// File: rtl/crc8_j1850_chk.sv
module crc8_j1850_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       byte_valid,
    input logic       frame_end,
    input logic [7:0] crc_out,
    input logic       crc_ok,
    input logic       frame_open,
    input logic       any_byte,
    input logic       mode_latched
);

    a_r2_preset_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (crc_out == 8'h00) && !crc_ok);

    a_r8_ok_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !(frame_end && frame_open)) |=> $stable(crc_ok));

    a_r9_no_byte_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_open && !frame_start && byte_valid) |=> $stable(crc_out));

    a_r7_empty_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_open && frame_end && !frame_start && !byte_valid && !any_byte) |=> !crc_ok);

    a_r5_pass_residue: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok && mode_latched) |-> (crc_out == 8'h3B));

endmodule

bind crc8_j1850 crc8_j1850_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .byte_valid   (byte_valid),
    .frame_end    (frame_end),
    .crc_out      (crc_out),
    .crc_ok       (crc_ok),
    .frame_open   (frame_open),
    .any_byte     (any_byte_q),
    .mode_latched (mode_q)
);

// File: tb/test_crc8_j1850.sv
module test_crc8_j1850;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       mode_rx = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       byte_valid = 1'b0;
    logic       frame_end = 1'b0;
    logic [7:0] crc_out;
    logic       crc_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] crc;
        logic       ok;
        string      req;
    } exp_t;
    exp_t sb[$];

    // bench model
    logic [7:0] m_rem = 8'hFF;
    bit m_open = 0, m_ok = 0, m_seen = 0, m_mode = 0;

    always #5 clk = ~clk;

    crc8_j1850 i_crc8_j1850 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_rx(mode_rx),
        .byte_in(byte_in), .byte_valid(byte_valid), .frame_end(frame_end),
        .crc_out(crc_out), .crc_ok(crc_ok)
    );

    function automatic logic [7:0] ref_step(input logic [7:0] r, input logic [7:0] d);
        logic [7:0] x;
        x = r ^ d;
        for (int k = 0; k < 8; k++)
            x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
        return x;
    endfunction

    task automatic cmp8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input bit st, input bit md, input bit vl,
                        input logic [7:0] d, input bit en, input string req);
        @(negedge clk);
        frame_start = st; mode_rx = md; byte_valid = vl; byte_in = d; frame_end = en;
        if (st) begin
            m_rem = 8'hFF; m_ok = 0; m_seen = 0; m_mode = md; m_open = 1;
        end else begin
            if (vl && m_open) begin m_rem = ref_step(m_rem, d); m_seen = 1; end
            if (en && m_open) begin
                m_ok = m_seen && (!m_mode || m_rem == 8'hC4);
                m_open = 0;
            end
        end
        if (en) sb.push_back('{~m_rem, m_ok, req});
    endtask

    // idle for one cycle, then compare outputs with the model
    task automatic check_now(input string req);
        @(negedge clk);
        frame_start = 0; byte_valid = 0; frame_end = 0;
        cmp8({req, " crc_out"}, crc_out, ~m_rem);
        cmp8({req, " crc_ok"}, {7'd0, crc_ok}, {7'd0, m_ok});
    endtask

    // monitor: pop expected result after each frame_end edge
    initial begin
        forever begin
            @(posedge clk);
            if (frame_end && rst_n) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL scoreboard empty actual=result expected=none");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    cmp8({e.req, " crc_out"}, crc_out, e.crc);
                    cmp8({e.req, " crc_ok"}, {7'd0, crc_ok}, {7'd0, e.ok});
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    logic [7:0] vec [9];
    logic [7:0] fr [8];

    initial begin
        foreach (vec[i]) vec[i] = 8'h31 + 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check_now("R1");
        cmp8("R1 crc_out literal", crc_out, 8'h00);

        // R9 byte before any frame
        tick(0, 0, 1, 8'hA5, 0, "R9");
        check_now("R9 idle byte");

        // R4 / R3 / R11 transmit known vector
        tick(1, 0, 0, 8'h00, 0, "R2");
        tick(0, 0, 1, vec[0], 0, "R3");
        check_now("R3 first byte");
        for (int i = 1; i < 9; i++) tick(0, 0, 1, vec[i], 0, "R3");
        check_now("R3 nine bytes");
        cmp8("R4 known vector", crc_out, 8'h4B);
        tick(0, 0, 0, 8'h00, 1, "R11 tx nonempty ok");
        check_now("R11");

        // R9 bytes after close; R8 stray end ignored
        tick(0, 0, 1, 8'h77, 0, "R9");
        check_now("R9 closed byte");
        tick(0, 1, 0, 8'h00, 1, "R8 stray end");
        check_now("R8");

        // R5 receive with correct check byte, mode toggled mid-frame (R11)
        tick(1, 1, 0, 8'h00, 0, "R2");
        for (int i = 0; i < 9; i++) tick(0, i[0], 1, vec[i], 0, "R11");
        tick(0, 0, 1, 8'h4B, 0, "R5");
        tick(0, 0, 0, 8'h00, 1, "R5 rx pass");
        check_now("R5");
        cmp8("R5 residue", crc_out, 8'h3B);

        // R6 corrupted payload
        tick(1, 1, 0, 8'h00, 0, "R2");
        for (int i = 0; i < 9; i++) tick(0, 1, 1, (i == 4) ? vec[i] ^ 8'h10 : vec[i], 0, "R6");
        tick(0, 1, 1, 8'h4B, 0, "R6");
        tick(0, 1, 0, 8'h00, 1, "R6 corrupted payload");

        // R6 bad check byte, R10 byte with end in same cycle
        tick(1, 1, 0, 8'h00, 0, "R2");
        for (int i = 0; i < 9; i++) tick(0, 1, 1, vec[i], 0, "R6");
        tick(0, 1, 1, 8'h4A, 1, "R6 bad check byte");
        tick(1, 1, 0, 8'h00, 0, "R2");
        for (int i = 0; i < 9; i++) tick(0, 1, 1, vec[i], 0, "R10");
        tick(0, 1, 1, 8'h4B, 1, "R10 byte with end");

        // R7 empty frames in both modes
        tick(1, 0, 0, 8'h00, 0, "R7");
        tick(0, 0, 0, 8'h00, 1, "R7 empty tx");
        tick(1, 1, 0, 8'h00, 0, "R7");
        tick(0, 1, 0, 8'h00, 1, "R7 empty rx");

        // R2 start wins over byte and end
        tick(1, 0, 0, 8'h00, 0, "R2");
        tick(0, 0, 1, 8'h12, 0, "R2");
        tick(1, 0, 1, 8'h34, 1, "R2 start priority");
        check_now("R2 preset");
        cmp8("R2 preset literal", crc_out, 8'h00);

        // random frames: generate then check
        for (int f = 0; f < 6; f++) begin
            logic [7:0] gen;
            int len;
            len = 1 + (f % 8);
            for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
            tick(1, 0, 0, 8'h00, 0, "R3");
            for (int i = 0; i < len; i++) tick(0, 0, 1, fr[i], 0, "R3");
            tick(0, 0, 0, 8'h00, 1, "R3 random tx");
            gen = ~m_rem;
            tick(1, 1, 0, 8'h00, 0, "R5");
            for (int i = 0; i < len; i++) tick(0, 1, 1, fr[i], 0, "R5");
            tick(0, 1, 1, gen, 0, "R5");
            tick(0, 1, 0, 8'h00, 1, "R5 random rx");
        end
        check_now("R8 final hold");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        summary();
    end

endmodule